// File: doc/BRIEF.md
# Iterative Signed/Unsigned Divider

This block divides two 64-bit operands over many clock cycles. It returns either the quotient or the remainder. It uses restoring division with one quotient bit per step. The working register is twice the operand width: the partial remainder sits in its upper half, and the dividend bits leave its lower half as the quotient bits enter it. When the upper 72 bits of that register are zero, the next eight quotient bits must be zero, so the block takes eight steps in a single cycle.

A caller presents the operands and two mode flags with a one-cycle `start`. The flags select signed or unsigned operation and quotient or remainder. In signed mode, negative operands are first converted to magnitudes in one extra cycle. The sign of the result is restored in a final cycle. The result appears with a one-cycle `done` pulse and holds until the next operation completes.

Top module: `iter_divider`

## Requirements
- R1: After reset, `done` is 0 and `result` is 0.
- R2: With `is_signed`=0, the operands are unsigned. `want_mod`=0 returns the floor quotient and `want_mod`=1 returns the remainder.
- R3: With `is_signed`=1 and `want_mod`=0, the operands are two's-complement. The quotient is truncated toward zero and is negative exactly when one operand is negative.
- R4: With `is_signed`=1 and `want_mod`=1, the remainder has magnitude |a| mod |b| and takes the sign of the dividend.
- R5: A divisor of zero yields a result of 0, and `done` still pulses after the normal step count (65 cycles for an unsigned all-ones dividend).
- R6: An unsigned operation whose dividend never triggers the shortcut raises `done` on the 65th rising edge after the edge that samples `start`. An example is an all-ones dividend divided by 3.
- R7: A signed operation with a negative operand spends one extra cycle. A dividend of 0x8000_0000_0000_0001 divided by 3 completes on the 66th edge.
- R8: When the top 72 bits of the working register are zero and fewer than 56 steps are done, eight zero quotient bits are taken in one cycle. Unsigned 5 divided by 3 completes on the 16th edge with quotient 1.
- R9: A `start` while an operation is in progress is ignored. The running operation finishes with its own operands and latency.
- R10: `done` is high for exactly one cycle, and `result` keeps its value after `done` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled only when idle) |
| dividend | input | 64 | Dividend, two's-complement when signed |
| divisor | input | 64 | Divisor, two's-complement when signed |
| is_signed | input | 1 | 1 = signed operands |
| want_mod | input | 1 | 1 = return remainder, 0 = return quotient |
| result | output | 64 | Quotient or remainder |
| done | output | 1 | One-cycle pulse marking a valid result |

## Verification
The bench exercises every sign combination for both quotient and remainder. A wrong sign rule would show up as a negated quotient, or as a remainder carrying the divisor's sign. Exact cycle counts are checked for the non-skip, negation and skip paths. A mis-gated shortcut would either finish early with wrong low bits or never shorten small divisions. Divisor-zero cases must return zero rather than all ones, and must not hang. A second `start` during a run must not change the operands of the run in progress.

// File: rtl/iter_divider.sv
module iter_divider #(
  parameter int W    = 64,
  parameter int SKIP = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  input  logic         is_signed,
  input  logic         want_mod,
  output logic [W-1:0] result,
  output logic         done
);
  localparam int CW = $clog2(W + 1);

  typedef enum logic [1:0] {IDLE, NEG, RUN, FIN} st_t;

  st_t            st;
  logic [2*W-1:0] acc;
  logic [W-1:0]   dsr;
  logic [CW-1:0]  cnt;
  logic           neg_a, neg_b, neg_res, mod_q, dz;

  wire          sa    = is_signed & dividend[W-1];
  wire          sb    = is_signed & divisor[W-1];
  wire [W:0]    trial = acc[2*W-1:W-1];
  wire [W:0]    diff  = trial - {1'b0, dsr};
  wire          fits  = ~diff[W];
  wire [W-1:0]  rem_n = fits ? diff[W-1:0] : trial[W-1:0];
  wire          skip  = ~|acc[2*W-1:W-SKIP] && (cnt < CW'(W - SKIP));
  wire [W-1:0]  pick  = mod_q ? acc[2*W-1:W] : acc[W-1:0];
  wire [W-1:0]  fin   = dz ? '0 : (neg_res ? -pick : pick);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= IDLE;
      acc     <= '0;
      dsr     <= '0;
      cnt     <= '0;
      neg_a   <= 1'b0;
      neg_b   <= 1'b0;
      neg_res <= 1'b0;
      mod_q   <= 1'b0;
      dz      <= 1'b0;
      result  <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          acc     <= {{W{1'b0}}, dividend};
          dsr     <= divisor;
          cnt     <= '0;
          neg_a   <= sa;
          neg_b   <= sb;
          neg_res <= want_mod ? sa : (sa ^ sb);
          mod_q   <= want_mod;
          dz      <= (divisor == '0);
          st      <= (sa | sb) ? NEG : RUN;
        end
        NEG: begin
          if (neg_a) acc[W-1:0] <= -acc[W-1:0];
          if (neg_b) dsr <= -dsr;
          st <= RUN;
        end
        RUN: begin
          if (skip) begin
            acc <= acc << SKIP;
            cnt <= cnt + CW'(SKIP);
          end else begin
            acc <= {rem_n, acc[W-2:0], fits};
            cnt <= cnt + CW'(1);
            if (cnt == CW'(W - 1)) st <= FIN;
          end
        end
        FIN: begin
          result <= fin;
          done   <= 1'b1;
          st     <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != IDLE && start) |=> ($stable(mod_q) && $stable(neg_res) && $stable(dz)));

  // R8
  step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RUN) |=> (cnt == $past(cnt) + CW'(1) || cnt == $past(cnt) + CW'(SKIP)));

  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(W));

  // R5
  zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && dz) |-> (result == '0));

  // R6
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(st) == FIN));
endmodule

// File: tb/iter_divider_bench.sv
`timescale 1ns/1ps
module iter_divider_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] dividend = '0;
  logic [63:0] divisor = '0;
  logic        is_signed = 1'b0;
  logic        want_mod = 1'b0;
  logic [63:0] result;
  logic        done;

  int total = 0;
  int fails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  iter_divider u_iter_divider (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
    .divisor(divisor), .is_signed(is_signed), .want_mod(want_mod),
    .result(result), .done(done)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      total = total + 1;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  localparam int NV = 14;
  localparam logic [63:0] TA [NV] = '{
    64'd100, 64'd100, -64'd100, -64'd100, 64'd100, 64'd100, -64'd100,
    -64'd100, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF,
    64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 64'd7, 64'd7};
  localparam logic [63:0] TB [NV] = '{
    64'd7, 64'd7, 64'd7, 64'd7, -64'd7, -64'd7, -64'd7, -64'd7,
    64'd2, 64'd10, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 64'd100, 64'd100};
  localparam logic TS [NV] = '{0,0,1,1,1,1,1,1,0,0,1,0,0,0};
  localparam logic TM [NV] = '{0,1,0,1,0,1,0,1,0,1,0,0,0,1};
  localparam logic [63:0] TE [NV] = '{
    64'd14, 64'd2, -64'd14, -64'd2, -64'd14, 64'd2, 64'd14, -64'd2,
    64'h7FFF_FFFF_FFFF_FFFF, 64'd5, 64'd1, 64'h2AAA_AAAA_AAAA_AAAA,
    64'd0, 64'd7};

  function automatic logic [63:0] model(logic [63:0] a, logic [63:0] b,
                                        logic s, logic m);
    logic na, nb;
    logic [63:0] ma, mb, v;
    if (b == 64'd0) return 64'd0;
    na = s & a[63];
    nb = s & b[63];
    ma = na ? -a : a;
    mb = nb ? -b : b;
    v  = m ? (ma % mb) : (ma / mb);
    return (m ? na : (na ^ nb)) ? -v : v;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    total = total + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [63:0] a, input logic [63:0] b,
                        input logic s, input logic m, input int inject_at,
                        output logic [63:0] res, output int lat);
    @(negedge clk);
    dividend = a; divisor = b; is_signed = s; want_mod = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (1) begin
      if (inject_at != 0 && lat == inject_at) begin
        dividend = 64'd100; divisor = 64'd7; is_signed = 1'b1;
        want_mod = ~m; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      lat = lat + 1;
      if (done) break;
      if (lat > 300) break;
    end
    res = result;
  endtask

  initial begin
    logic [63:0] r, a, b;
    int lat;
    repeat (3) @(negedge clk);
    check(done === 1'b0, "R1 done", {63'd0, done}, 64'd0);
    check(result === 64'd0, "R1 result", result, 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      run_op(TA[i], TB[i], TS[i], TM[i], 0, r, lat);
      check(r === TE[i], TS[i] ? (TM[i] ? "R4 table" : "R3 table") : "R2 table",
            r, TE[i]);
    end

    for (int i = 0; i < 150; i++) begin
      logic s, m;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (i % 3 == 0) a = a >> (40 + $urandom % 24);
      if (i % 2 == 0) b = b >> ($urandom % 64);
      s = i[0];
      m = i[1];
      run_op(a, b, s, m, 0, r, lat);
      check(r === model(a, b, s, m), s ? (m ? "R4 random" : "R3 random") : "R2 random",
            r, model(a, b, s, m));
    end

    run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 1'b0, 1'b0, 0, r, lat);
    check(lat == 65, "R6 latency", 64'(lat), 64'd65);
    check(r === 64'h5555_5555_5555_5555, "R6 value", r, 64'h5555_5555_5555_5555);
    @(negedge clk);
    check(done === 1'b0, "R10 pulse", {63'd0, done}, 64'd0);
    check(result === 64'h5555_5555_5555_5555, "R10 hold", result, 64'h5555_5555_5555_5555);

    run_op(64'h8000_0000_0000_0001, 64'd3, 1'b1, 1'b0, 0, r, lat);
    check(lat == 66, "R7 latency", 64'(lat), 64'd66);
    check(r === model(64'h8000_0000_0000_0001, 64'd3, 1'b1, 1'b0), "R7 value",
          r, model(64'h8000_0000_0000_0001, 64'd3, 1'b1, 1'b0));

    run_op(64'd5, 64'd3, 1'b0, 1'b0, 0, r, lat);
    check(lat == 16, "R8 latency", 64'(lat), 64'd16);
    check(r === 64'd1, "R8 value", r, 64'd1);
    run_op(64'd5, 64'd3, 1'b0, 1'b1, 0, r, lat);
    check(r === 64'd2, "R8 remainder", r, 64'd2);

    run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1'b0, 1'b0, 0, r, lat);
    check(r === 64'd0, "R5 quotient", r, 64'd0);
    check(lat == 65, "R5 latency", 64'(lat), 64'd65);
    run_op(-64'd5, 64'd0, 1'b1, 1'b1, 0, r, lat);
    check(r === 64'd0, "R5 signed remainder", r, 64'd0);

    run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 1'b0, 1'b0, 10, r, lat);
    check(r === 64'h5555_5555_5555_5555, "R9 value", r, 64'h5555_5555_5555_5555);
    check(lat == 65, "R9 latency", 64'(lat), 64'd65);
    repeat (3) @(negedge clk);
    check(done === 1'b0, "R9 no second run", {63'd0, done}, 64'd0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule